// File: doc/BRIEF.md
# Split-Transaction Register Access Router

This block takes one register access command at a time from a processor core and carries it out as an ordered pair of bus phases. A command names an operation (read, write or fast write), a target kind (slow peripheral bus, local register bus, or a remote core's register reached by reflection), an address, the requester's ID and an immediate data word. The router moves the data between the requester and the target. A pull bus fetches write data from a source. A push bus delivers data to a destination.

Each bus is modelled as a plain request/acknowledge port. A request stays high until its acknowledge is seen at a clock edge. The next phase's request rises in the following cycle. Data captured in one phase is held in a single data register and driven out in the next phase. Pull and push requests carry a mode bit. The bit says whether the transfer is steered by the address (1) or by the requester ID (0). The router accepts nothing new until the last phase of a command completes.

Top module: `xr_router`

## Requirements
- R1: `cmd_ready` is 1 after reset and whenever the router is idle. It is 0 from the cycle after a legal command is accepted (`cmd_valid` and `cmd_ready` high at a clock edge) until the cycle after the final phase's acknowledge. No bus request is ever high while `cmd_ready` is 1.
- R2: A peripheral read (`cmd_op`=0, `cmd_tgt`=0) first raises `per_req` with `per_we`=0. It then raises `push_req`, and `push_data` equals the `per_rdata` captured at the peripheral acknowledge.
- R3: A peripheral write (`cmd_op`=1, `cmd_tgt`=0) first raises `pull_req`. It then raises `per_req` with `per_we`=1, and `per_wdata` equals the captured `pull_data`.
- R4: A local read (`cmd_op`=0, `cmd_tgt`=1) first raises `reg_req` with `reg_we`=0. It then raises `push_req`, and `push_data` equals the captured `reg_rdata`.
- R5: A local write (`cmd_op`=1, `cmd_tgt`=1) first raises `pull_req`. It then raises `reg_req` with `reg_we`=1, and `reg_wdata` equals the captured `pull_data`.
- R6: A fast write to a local register (`cmd_op`=2, `cmd_tgt`=1) performs a single `reg_req` phase with `reg_we`=1 and `reg_wdata` equal to `cmd_data`. No pull phase occurs.
- R7: A reflector read (`cmd_op`=0, `cmd_tgt`=2) first raises `pull_req` with `pull_by_addr`=1. It then raises `push_req` with `push_by_addr`=0, and `push_data` equals the captured `pull_data`.
- R8: A reflector write (`cmd_op`=1, `cmd_tgt`=2) first raises `pull_req` with `pull_by_addr`=0. It then raises `push_req` with `push_by_addr`=1, and `push_data` equals the captured `pull_data`. In every non-reflector phase, both mode bits are 0.
- R9: At most one bus request is high in any cycle. A request and its address stay unchanged until its acknowledge. The next phase's request, or `cmd_ready` after the last phase, appears in the cycle right after that acknowledge.
- R10: Every phase presents the accepted command's address on its address port. Every pull and push phase presents the accepted requester ID unchanged.
- R11: An illegal command has no bus activity. Illegal commands are a fast write to a peripheral or reflector target, operation code 3, or target code 3. It raises `err_reject` for exactly the one cycle after acceptance and leaves `cmd_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Router idle and able to accept |
| cmd_op | input | 2 | 0 read, 1 write, 2 fast write, 3 reserved |
| cmd_tgt | input | 2 | 0 peripheral, 1 local register, 2 reflector, 3 reserved |
| cmd_addr | input | AW | Target address |
| cmd_id | input | IW | Requester ID |
| cmd_data | input | DW | Immediate data for fast write |
| err_reject | output | 1 | One-cycle pulse on an illegal command |
| pull_req | output | 1 | Pull phase request |
| pull_by_addr | output | 1 | Pull steered by address (1) or ID (0) |
| pull_id | output | IW | Requester ID for the pull |
| pull_addr | output | AW | Address for the pull |
| pull_ack | input | 1 | Pull acknowledge, data valid |
| pull_data | input | DW | Pulled data |
| push_req | output | 1 | Push phase request |
| push_by_addr | output | 1 | Push steered by address (1) or ID (0) |
| push_id | output | IW | Requester ID for the push |
| push_addr | output | AW | Address for the push |
| push_data | output | DW | Data being pushed |
| push_ack | input | 1 | Push acknowledge |
| per_req | output | 1 | Peripheral bus request |
| per_we | output | 1 | Peripheral write (1) or read (0) |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | DW | Peripheral read data |
| reg_req | output | 1 | Local register bus request |
| reg_we | output | 1 | Register write (1) or read (0) |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Register acknowledge |
| reg_rdata | input | DW | Register read data |

## Verification
A bad phase plan shows up in the very first cycle after acceptance as the wrong request line, and a bad transition shows up in the cycle after an acknowledge. A stuck sequencer shows as `cmd_ready` staying low one cycle past the final acknowledge. A bad capture in the data register is visible one phase later, on `push_data` or the write data of the second phase. A wrong legality decode shows either as a missing `err_reject` pulse or as a request rising one cycle after acceptance. The bench sweeps every operation and target code against several acknowledge delays, so each of these faults is caught within a few cycles of the command that exposes it.

// File: rtl/xr_pkg.sv
// Shared encodings for the split-transaction router.
// Assumes 2-bit operation and target codes as listed in the brief.
package xr_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FAST  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TG_PERIPH = 2'd0,
        TG_LOCAL  = 2'd1,
        TG_REMOTE = 2'd2,
        TG_RSVD   = 2'd3
    } tgt_e;

    // Bus code minus one is the bit index in the request vector.
    typedef enum logic [2:0] {
        BUS_NONE   = 3'd0,
        BUS_PULL   = 3'd1,
        BUS_PUSH   = 3'd2,
        BUS_PERIPH = 3'd3,
        BUS_REG    = 3'd4
    } bus_e;

    localparam int NUM_BUS = 4;

    typedef struct packed {
        bus_e first;
        bus_e second;
        logic tgt_write;
        logic pull_by_addr;
        logic push_by_addr;
    } plan_t;

    localparam plan_t PLAN_IDLE = '{BUS_NONE, BUS_NONE, 1'b0, 1'b0, 1'b0};

endpackage

// File: rtl/xr_decode.sv
// Maps an operation/target pair onto an ordered pair of bus phases.
// Purely combinational; assumes codes are sampled only at acceptance.
module xr_decode
    import xr_pkg::*;
(
    input  logic [1:0] op,
    input  logic [1:0] tgt,
    output logic       legal,
    output plan_t      plan
);

    // Choose the phase plan and legality for the offered command.
    always_comb begin
        legal = 1'b0;
        plan  = PLAN_IDLE;
        case (tgt_e'(tgt))
            TG_PERIPH: begin
                case (op_e'(op))
                    OP_READ:  begin legal = 1'b1; plan = '{BUS_PERIPH, BUS_PUSH, 1'b0, 1'b0, 1'b0}; end
                    OP_WRITE: begin legal = 1'b1; plan = '{BUS_PULL, BUS_PERIPH, 1'b1, 1'b0, 1'b0}; end
                    default:  ;
                endcase
            end
            TG_LOCAL: begin
                case (op_e'(op))
                    OP_READ:  begin legal = 1'b1; plan = '{BUS_REG, BUS_PUSH, 1'b0, 1'b0, 1'b0}; end
                    OP_WRITE: begin legal = 1'b1; plan = '{BUS_PULL, BUS_REG, 1'b1, 1'b0, 1'b0}; end
                    OP_FAST:  begin legal = 1'b1; plan = '{BUS_REG, BUS_NONE, 1'b1, 1'b0, 1'b0}; end
                    default:  ;
                endcase
            end
            TG_REMOTE: begin
                case (op_e'(op))
                    OP_READ:  begin legal = 1'b1; plan = '{BUS_PULL, BUS_PUSH, 1'b0, 1'b1, 1'b0}; end
                    OP_WRITE: begin legal = 1'b1; plan = '{BUS_PULL, BUS_PUSH, 1'b0, 1'b0, 1'b1}; end
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xr_bus_mux.sv
// Fans the active phase out to one request line per bus and folds the
// acknowledges and return data back in. Assumes one phase active at most.
module xr_bus_mux
    import xr_pkg::*;
#(
    parameter int DW = 32
) (
    input  bus_e                cur_bus,
    input  logic [NUM_BUS-1:0]  ack_vec,
    input  logic [DW-1:0]       pull_data,
    input  logic [DW-1:0]       per_rdata,
    input  logic [DW-1:0]       reg_rdata,
    output logic [NUM_BUS-1:0]  req_vec,
    output logic                phase_ack,
    output logic [DW-1:0]       phase_rdata
);

    for (genvar i = 0; i < NUM_BUS; i++) begin : g_req
        assign req_vec[i] = (cur_bus == bus_e'(3'(i + 1)));
    end

    assign phase_ack = |(req_vec & ack_vec);

    // Pick the return data of the bus that is currently active.
    always_comb begin
        case (cur_bus)
            BUS_PULL:   phase_rdata = pull_data;
            BUS_PERIPH: phase_rdata = per_rdata;
            BUS_REG:    phase_rdata = reg_rdata;
            default:    phase_rdata = '0;
        endcase
    end

endmodule

// File: rtl/xr_seq.sv
// Phase sequencer: holds the accepted command, steps through its two
// phases on acknowledges, and captures returned data for the next phase.
// Assumes acceptance is only signalled while idle.
module xr_seq
    import xr_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_ok,
    input  logic          accept_bad,
    input  plan_t         plan_in,
    input  logic [AW-1:0] cmd_addr,
    input  logic [IW-1:0] cmd_id,
    input  logic [DW-1:0] cmd_data,
    input  logic          phase_ack,
    input  logic [DW-1:0] phase_rdata,
    output logic          busy,
    output bus_e          cur_bus,
    output plan_t         plan_q,
    output logic [AW-1:0] addr_q,
    output logic [IW-1:0] id_q,
    output logic [DW-1:0] data_q,
    output logic          err_q
);

    typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} state_e;

    state_e state;
    logic   capture;
    logic   last_phase;

    assign busy       = (state != ST_IDLE);
    assign last_phase = (state == ST_SECOND) || (plan_q.second == BUS_NONE);

    // Decode the bus that the current state drives.
    always_comb begin
        case (state)
            ST_FIRST:  cur_bus = plan_q.first;
            ST_SECOND: cur_bus = plan_q.second;
            default:   cur_bus = BUS_NONE;
        endcase
    end

    // A phase that brings data in: any pull, or a target-bus read.
    always_comb begin
        capture = 1'b0;
        if (phase_ack) begin
            if (cur_bus == BUS_PULL) begin
                capture = 1'b1;
            end else if ((cur_bus == BUS_PERIPH) || (cur_bus == BUS_REG)) begin
                capture = !plan_q.tgt_write;
            end
        end
    end

    // Advance the phase state on acceptance and acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (accept_ok) state <= ST_FIRST;
                ST_FIRST:  if (phase_ack) state <= last_phase ? ST_IDLE : ST_SECOND;
                ST_SECOND: if (phase_ack) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Latch the command's plan, address and ID at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= PLAN_IDLE;
            addr_q <= '0;
            id_q   <= '0;
        end else if (accept_ok) begin
            plan_q <= plan_in;
            addr_q <= cmd_addr;
            id_q   <= cmd_id;
        end
    end

    // Hold the data word: immediate at acceptance, returned data on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept_ok) begin
            data_q <= cmd_data;
        end else if (capture) begin
            data_q <= phase_rdata;
        end
    end

    // One-cycle rejection pulse for an illegal command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= accept_bad;
        end
    end

endmodule

// File: rtl/xr_router.sv
// Top of the split-transaction register access router. Accepts one command
// at a time and runs it as a pull/push/peripheral/register phase pair.
// Assumes a single requester port; arbitration lives upstream.
module xr_router
    import xr_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [1:0]    cmd_tgt,
    input  logic [AW-1:0] cmd_addr,
    input  logic [IW-1:0] cmd_id,
    input  logic [DW-1:0] cmd_data,
    output logic          err_reject,
    output logic          pull_req,
    output logic          pull_by_addr,
    output logic [IW-1:0] pull_id,
    output logic [AW-1:0] pull_addr,
    input  logic          pull_ack,
    input  logic [DW-1:0] pull_data,
    output logic          push_req,
    output logic          push_by_addr,
    output logic [IW-1:0] push_id,
    output logic [AW-1:0] push_addr,
    output logic [DW-1:0] push_data,
    input  logic          push_ack,
    output logic          per_req,
    output logic          per_we,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic          per_ack,
    input  logic [DW-1:0] per_rdata,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic          reg_ack,
    input  logic [DW-1:0] reg_rdata
);

    logic               dec_legal;
    plan_t              dec_plan;
    logic               busy;
    bus_e               cur_bus;
    plan_t              plan_q;
    logic [AW-1:0]      addr_q;
    logic [IW-1:0]      id_q;
    logic [DW-1:0]      data_q;
    logic [NUM_BUS-1:0] req_vec;
    logic               phase_ack;
    logic [DW-1:0]      phase_rdata;
    logic               accept;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    xr_decode u_decode (
        .op    (cmd_op),
        .tgt   (cmd_tgt),
        .legal (dec_legal),
        .plan  (dec_plan)
    );

    xr_seq #(.AW(AW), .IW(IW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_ok   (accept && dec_legal),
        .accept_bad  (accept && !dec_legal),
        .plan_in     (dec_plan),
        .cmd_addr    (cmd_addr),
        .cmd_id      (cmd_id),
        .cmd_data    (cmd_data),
        .phase_ack   (phase_ack),
        .phase_rdata (phase_rdata),
        .busy        (busy),
        .cur_bus     (cur_bus),
        .plan_q      (plan_q),
        .addr_q      (addr_q),
        .id_q        (id_q),
        .data_q      (data_q),
        .err_q       (err_reject)
    );

    xr_bus_mux #(.DW(DW)) u_mux (
        .cur_bus     (cur_bus),
        .ack_vec     ({reg_ack, per_ack, push_ack, pull_ack}),
        .pull_data   (pull_data),
        .per_rdata   (per_rdata),
        .reg_rdata   (reg_rdata),
        .req_vec     (req_vec),
        .phase_ack   (phase_ack),
        .phase_rdata (phase_rdata)
    );

    assign pull_req     = req_vec[0];
    assign pull_by_addr = plan_q.pull_by_addr;
    assign pull_id      = id_q;
    assign pull_addr    = addr_q;

    assign push_req     = req_vec[1];
    assign push_by_addr = plan_q.push_by_addr;
    assign push_id      = id_q;
    assign push_addr    = addr_q;
    assign push_data    = data_q;

    assign per_req      = req_vec[2];
    assign per_we       = plan_q.tgt_write;
    assign per_addr     = addr_q;
    assign per_wdata    = data_q;

    assign reg_req      = req_vec[3];
    assign reg_we       = plan_q.tgt_write;
    assign reg_addr     = addr_q;
    assign reg_wdata    = data_q;

endmodule

// File: rtl/xr_router_chk.sv
// Port-level protocol checks for xr_router, attached with bind.
module xr_router_chk #(
    parameter int AW = 16,
    parameter int IW = 4,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          err_reject,
    input logic          pull_req,
    input logic          pull_ack,
    input logic [IW-1:0] pull_id,
    input logic [AW-1:0] pull_addr,
    input logic          push_req,
    input logic          push_ack,
    input logic [IW-1:0] push_id,
    input logic [DW-1:0] push_data,
    input logic          per_req,
    input logic          per_ack,
    input logic [AW-1:0] per_addr,
    input logic          per_we,
    input logic          reg_req,
    input logic          reg_ack,
    input logic [AW-1:0] reg_addr,
    input logic          reg_we
);

    logic any_req;
    assign any_req = pull_req || push_req || per_req || reg_req;

    assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pull_req, push_req, per_req, reg_req}));

    assert_busy_while_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> !cmd_ready);

    assert_pull_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_req && !pull_ack) |=> (pull_req && $stable(pull_id) && $stable(pull_addr)));

    assert_push_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ack) |=> (push_req && $stable(push_id) && $stable(push_data)));

    assert_per_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_ack) |=> (per_req && $stable(per_addr) && $stable(per_we)));

    assert_reg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)));

    assert_err_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |-> $past(cmd_valid && cmd_ready));

    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |-> (cmd_ready && !any_req));

    assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |=> !err_reject);

endmodule

bind xr_router xr_router_chk #(.AW(AW), .IW(IW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .err_reject (err_reject),
    .pull_req   (pull_req),
    .pull_ack   (pull_ack),
    .pull_id    (pull_id),
    .pull_addr  (pull_addr),
    .push_req   (push_req),
    .push_ack   (push_ack),
    .push_id    (push_id),
    .push_data  (push_data),
    .per_req    (per_req),
    .per_ack    (per_ack),
    .per_addr   (per_addr),
    .per_we     (per_we),
    .reg_req    (reg_req),
    .reg_ack    (reg_ack),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we)
);

// File: tb/xr_router_test.sv
`timescale 1ns/100ps
module xr_router_test;

    localparam int AW = 12;
    localparam int IW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [1:0]    cmd_tgt = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [IW-1:0] cmd_id = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          err_reject;
    logic          pull_req, pull_by_addr;
    logic [IW-1:0] pull_id;
    logic [AW-1:0] pull_addr;
    logic          pull_ack = 1'b0;
    logic [DW-1:0] pull_data = '0;
    logic          push_req, push_by_addr;
    logic [IW-1:0] push_id;
    logic [AW-1:0] push_addr;
    logic [DW-1:0] push_data;
    logic          push_ack = 1'b0;
    logic          per_req, per_we;
    logic [AW-1:0] per_addr;
    logic [DW-1:0] per_wdata;
    logic          per_ack = 1'b0;
    logic [DW-1:0] per_rdata = '0;
    logic          reg_req, reg_we;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic          reg_ack = 1'b0;
    logic [DW-1:0] reg_rdata = '0;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    xr_router #(.AW(AW), .IW(IW), .DW(DW)) uut (.*);

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Bus codes: 0 none, 1 pull, 2 push, 3 peripheral, 4 register.
    function automatic int exp_phase(input int op, input int tgt, input int idx);
        int a, b;
        a = 0; b = 0;
        if (tgt == 0 && op == 0) begin a = 3; b = 2; end        // R2
        else if (tgt == 0 && op == 1) begin a = 1; b = 3; end   // R3
        else if (tgt == 1 && op == 0) begin a = 4; b = 2; end   // R4
        else if (tgt == 1 && op == 1) begin a = 1; b = 4; end   // R5
        else if (tgt == 1 && op == 2) begin a = 4; b = 0; end   // R6
        else if (tgt == 2 && op == 0) begin a = 1; b = 2; end   // R7
        else if (tgt == 2 && op == 1) begin a = 1; b = 2; end   // R8
        return (idx == 0) ? a : b;
    endfunction

    function automatic string req_tag(input int op, input int tgt);
        if (tgt == 0) return (op == 0) ? "R2" : "R3";
        if (tgt == 1) return (op == 0) ? "R4" : (op == 1) ? "R5" : "R6";
        return (op == 0) ? "R7" : "R8";
    endfunction

    function automatic int active_bus();
        int n;
        n = int'(pull_req) + int'(push_req) + int'(per_req) + int'(reg_req);
        if (n > 1) return -1;
        if (pull_req) return 1;
        if (push_req) return 2;
        if (per_req)  return 3;
        if (reg_req)  return 4;
        return 0;
    endfunction

    function automatic logic [DW-1:0] src_val(input int bus, input logic [AW-1:0] a,
                                              input logic [IW-1:0] id);
        logic [DW-1:0] base;
        base = (bus == 1) ? 16'hA000 : (bus == 3) ? 16'h5000 : 16'h7000;
        return base ^ DW'(a) ^ (DW'(id) << 13);
    endfunction

    task automatic run_cmd(input int op, input int tgt, input int dly,
                           input logic [AW-1:0] a, input logic [IW-1:0] id,
                           input logic [DW-1:0] d);
        bit            legal;
        int            nph;
        string         rq;
        logic [DW-1:0] cur;
        legal = (exp_phase(op, tgt, 0) != 0);
        nph   = (exp_phase(op, tgt, 1) != 0) ? 2 : 1;
        rq    = legal ? req_tag(op, tgt) : "R11";
        cur   = d;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_tgt = 2'(tgt);
        cmd_addr = a; cmd_id = id; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!legal) begin
            chk(err_reject == 1'b1, "R11", err_reject, 1);
            chk(cmd_ready == 1'b1 && active_bus() == 0, "R11", active_bus(), 0);
            @(negedge clk);
            chk(err_reject == 1'b0 && active_bus() == 0, "R11", err_reject, 0);
            return;
        end
        chk(cmd_ready == 1'b0, "R1", cmd_ready, 0);
        chk(err_reject == 1'b0, "R11", err_reject, 0);
        for (int p = 0; p < nph; p++) begin
            int eb;
            eb = exp_phase(op, tgt, p);
            for (int w = 0; w <= dly; w++) begin
                chk(active_bus() == eb, (w == 0) ? rq : "R9", active_bus(), eb);
                if (w == 0) begin
                    case (eb)
                        1: begin
                            chk(pull_id == id && pull_addr == a, "R10", pull_id, id);
                            chk(pull_by_addr == (tgt == 2 && op == 0), rq, pull_by_addr, (tgt == 2 && op == 0));
                        end
                        2: begin
                            chk(push_id == id && push_addr == a, "R10", push_id, id);
                            chk(push_by_addr == (tgt == 2 && op == 1), rq, push_by_addr, (tgt == 2 && op == 1));
                            chk(push_data == cur, rq, push_data, cur);
                        end
                        3: begin
                            chk(per_addr == a, "R10", per_addr, a);
                            chk(per_we == (op != 0), rq, per_we, (op != 0));
                            if (op != 0) chk(per_wdata == cur, rq, per_wdata, cur);
                        end
                        default: begin
                            chk(reg_addr == a, "R10", reg_addr, a);
                            chk(reg_we == (op != 0), rq, reg_we, (op != 0));
                            if (op != 0) chk(reg_wdata == cur, rq, reg_wdata, cur);
                        end
                    endcase
                end
                if (w == dly) begin
                    logic [DW-1:0] v;
                    v = src_val(eb, a, id);
                    case (eb)
                        1: begin pull_ack = 1'b1; pull_data = v; cur = v; end
                        2: push_ack = 1'b1;
                        3: begin per_ack = 1'b1; per_rdata = v; if (op == 0) cur = v; end
                        default: begin reg_ack = 1'b1; reg_rdata = v; if (op == 0) cur = v; end
                    endcase
                end
                @(negedge clk);
                pull_ack = 1'b0; push_ack = 1'b0; per_ack = 1'b0; reg_ack = 1'b0;
            end
        end
        chk(cmd_ready == 1'b1 && active_bus() == 0, "R1", cmd_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        chk(err_reject == 1'b0 && active_bus() == 0, "R11", active_bus(), 0);
        rst_n = 1'b1;
        for (int dly = 0; dly < 3; dly++) begin
            for (int op = 0; op < 4; op++) begin
                for (int tgt = 0; tgt < 4; tgt++) begin
                    logic [AW-1:0] a;
                    logic [IW-1:0] id;
                    a  = AW'(12'h135 * (op * 4 + tgt + 1) + dly);
                    id = IW'(op + tgt * 3 + dly);
                    run_cmd(op, tgt, dly, a, id, DW'(16'hF00D ^ (op * 16 + tgt + dly * 64)));
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule